// File: doc/BRIEF.md
# DDR Prefetch Burst Serializer

This block turns wide read data from a memory core into a double-data-rate stream on a 16-bit interface. The interface is split into a lower byte lane and an upper byte lane, and each lane has its own strobe pair. Each core word holds four interface items, so it is four times the interface width. The block shifts those items out one per half period of the interface clock, which gives two items per clock period. A burst carries four items (one core word) or eight items (two consecutive core words). One launch pulse sequences the whole burst.

The strobe is edge-aligned with the data, so every strobe transition coincides with a data transition. Before the first item the strobe is driven low for one full clock period as a preamble. After the last item it is held low for half a period as a postamble, and then the lane is released.

The double-rate timing is modelled synchronously. `clk` is the double-rate tick: one tick is half an interface clock period, so one core beat is two ticks. All outputs are registered state decoded each tick.

A configuration input can switch the upper lane off for a single-byte device. A launch that arrives on the last data tick of a burst chains the next burst with no gap and no preamble.

Top module: `ddr_burst_serializer`

## Requirements
- R1: After synchronous reset, all four enables are low, both data lanes read 0, each true strobe reads 0 and each complement strobe reads 1.
- R2: A launch taken from idle gives two ticks of preamble: strobe enable high, strobe low, data enable low. The first data item follows on the next tick.
- R3: Item i of a core word is bits [16i+15:16i], i from 0 to 3. Items appear in ascending order, one per tick, with the data enable high. A burst of four ends after item 3.
- R4: During data ticks the strobe is high on even items and low on odd items, so it toggles on every data tick.
- R5: With the eight-item burst select set at launch, `core_word` is sampled a second time on the edge that ends item 3, which is six ticks after the launch edge when a preamble was sent. Its items become items 4 to 7.
- R6: After the last item, one postamble tick follows with the strobe enable high, the strobe low and the data enable low. On the next tick every enable is low.
- R7: Bits [7:0] of each item go to the lower lane and bits [15:8] go to the upper lane. Each lane's strobe pair has its complement equal to the inverse of its true strobe.
- R8: While `hi_off` is 1, the upper data, strobe and enable outputs hold their reset values. The lower lane is unchanged.
- R9: A launch is ignored during the preamble and during any data tick except the last.
- R10: A launch on the last data tick starts the new burst on the next tick with its item 0. No postamble or preamble is inserted.
- R11: A launch during the postamble tick starts a normal burst with a full two-tick preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate tick clock |
| rst | input | 1 | Synchronous reset, active high |
| launch | input | 1 | Read burst start pulse |
| burst8 | input | 1 | 1 selects an eight-item burst, 0 a four-item burst |
| hi_off | input | 1 | Disables the upper byte lane |
| core_word | input | 64 | Prefetched core word (four 16-bit items) |
| dq_lo | output | 8 | Lower lane data |
| dq_lo_oe | output | 1 | Lower lane data drive enable |
| dqs_lo | output | 1 | Lower lane strobe, true |
| dqs_lo_n | output | 1 | Lower lane strobe, complement |
| dqs_lo_oe | output | 1 | Lower lane strobe drive enable |
| dq_hi | output | 8 | Upper lane data |
| dq_hi_oe | output | 1 | Upper lane data drive enable |
| dqs_hi | output | 1 | Upper lane strobe, true |
| dqs_hi_n | output | 1 | Upper lane strobe, complement |
| dqs_hi_oe | output | 1 | Upper lane strobe drive enable |

## Verification
The vector table applies bursts of both lengths, with the upper lane on and off. The words use distinct byte values, so a swapped item, a swapped lane or a stale second word shows up as a wrong byte. One word is all ones and one alternates bits, which separates a lane that holds a constant from one that really shifts.

Directed runs then place launches at chosen points of a burst:
- during the preamble and mid-data, where the launch must be ignored;
- on the last data tick, where the next burst must chain with no gap;
- in the postamble, where a full preamble must follow.

Each of these launch positions separates a different acceptance condition.

// File: rtl/ddr_burst_serializer.sv
module ddr_burst_serializer #(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  launch,
  input  logic                  burst8,
  input  logic                  hi_off,
  input  logic [8*LANE_W-1:0]   core_word,
  output logic [LANE_W-1:0]     dq_lo,
  output logic                  dq_lo_oe,
  output logic                  dqs_lo,
  output logic                  dqs_lo_n,
  output logic                  dqs_lo_oe,
  output logic [LANE_W-1:0]     dq_hi,
  output logic                  dq_hi_oe,
  output logic                  dqs_hi,
  output logic                  dqs_hi_n,
  output logic                  dqs_hi_oe
);
  localparam int ITEM_W = 2 * LANE_W;
  localparam int WORD_W = 4 * ITEM_W;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA, S_POST} st_t;

  st_t               st;
  logic [2:0]        idx;
  logic              pre_cnt;
  logic              bl8_q;
  logic [WORD_W-1:0] sh;
  logic [ITEM_W-1:0] item;

  wire last = (st == S_DATA) && (idx == {bl8_q, 2'b11});
  wire take = launch && ((st == S_IDLE) || (st == S_POST) || last);
  wire dv   = (st == S_DATA);
  wire sv   = (st != S_IDLE);
  wire lvl  = dv && !idx[0];
  wire hon  = !hi_off;

  assign item = sh[idx[1:0]*ITEM_W +: ITEM_W];

  assign dq_lo     = dv ? item[LANE_W-1:0] : '0;
  assign dq_lo_oe  = dv;
  assign dqs_lo    = lvl;
  assign dqs_lo_n  = !lvl;
  assign dqs_lo_oe = sv;

  assign dq_hi     = (dv && hon) ? item[ITEM_W-1:LANE_W] : '0;
  assign dq_hi_oe  = dv && hon;
  assign dqs_hi    = lvl && hon;
  assign dqs_hi_n  = !(lvl && hon);
  assign dqs_hi_oe = sv && hon;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      idx     <= '0;
      pre_cnt <= 1'b0;
      bl8_q   <= 1'b0;
      sh      <= '0;
    end else if (take) begin
      sh      <= core_word;
      bl8_q   <= burst8;
      idx     <= '0;
      pre_cnt <= 1'b0;
      st      <= last ? S_DATA : S_PRE;
    end else begin
      case (st)
        S_PRE: begin
          if (pre_cnt) st <= S_DATA;
          pre_cnt <= 1'b1;
        end
        S_DATA: begin
          if (last) st <= S_POST;
          else begin
            idx <= idx + 3'd1;
            if (idx == 3'd3) sh <= core_word;
          end
        end
        S_POST:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_pre_low_r2: assert property (@(posedge clk) disable iff (rst)
    (dqs_lo_oe && !dq_lo_oe) |-> !dqs_lo);

  p_data_after_pre_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_lo_oe) |-> $past(dqs_lo_oe));

  p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (dq_lo_oe && $past(dq_lo_oe)) |-> (dqs_lo != $past(dqs_lo)));

  p_post_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(dqs_lo_oe) |-> !$past(dq_lo_oe));

  p_hi_off_r8: assert property (@(posedge clk) disable iff (rst)
    hi_off |-> (!dq_hi_oe && !dqs_hi_oe && dq_hi == '0));

  p_post_follows_data_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_POST) |-> $past(st == S_DATA));
endmodule

// File: tb/ddr_burst_serializer_bench.sv
module ddr_burst_serializer_bench;
  localparam int CLK_T = 10;
  localparam int NV = 5;
  localparam logic [63:0] W0 [NV] = '{64'h4433_2211_ABCD_0F1E, 64'h8877_6655_4433_2211,
    64'h1357_9BDF_2468_ACE0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hA55A_5AA5_C33C_3CC3};
  localparam logic [63:0] W1 [NV] = '{64'h0, 64'hFEDC_BA98_7654_3210,
    64'h0, 64'h0123_4567_89AB_CDEF, 64'h5AA5_A55A_3CC3_C33C};
  localparam logic B8 [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic HO [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0, rst = 1'b1, launch = 1'b0, burst8 = 1'b0, hi_off = 1'b0;
  logic [63:0] core_word = '0;
  logic [7:0] dq_lo, dq_hi;
  logic dq_lo_oe, dqs_lo, dqs_lo_n, dqs_lo_oe, dq_hi_oe, dqs_hi, dqs_hi_n, dqs_hi_oe;
  int nchk = 0, nfail = 0;

  always #(CLK_T/2) clk = ~clk;

  ddr_burst_serializer u_ddr_burst_serializer (.clk, .rst, .launch, .burst8, .hi_off,
    .core_word, .dq_lo, .dq_lo_oe, .dqs_lo, .dqs_lo_n, .dqs_lo_oe,
    .dq_hi, .dq_hi_oe, .dqs_hi, .dqs_hi_n, .dqs_hi_oe);

  wire [23:0] obs = {dq_hi, dq_lo, dq_hi_oe, dq_lo_oe, dqs_hi_oe, dqs_lo_oe,
                     dqs_hi, dqs_hi_n, dqs_lo, dqs_lo_n};

  // kind: 0 idle, 1 strobe driven low without data, 2 data
  function automatic logic [23:0] ev(int kind, logic [15:0] it, logic lv, logic ho);
    logic d = (kind == 2), s = (kind != 0), l = (kind == 2) && lv, h = !ho;
    return {(d && h) ? it[15:8] : 8'h00, d ? it[7:0] : 8'h00, d && h, d, s && h, s,
            l && h, !(l && h), l, !l};
  endfunction

  task automatic chk(string tag, logic [23:0] exp);
    nchk++;
    if (obs !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, obs, exp);
    end
  endtask

  // mode 0: end with post+idle, 1: chain on last item, 2: relaunch during post
  task automatic burst(logic [63:0] w0, logic [63:0] w1, logic b8, logic ho,
                       logic preset, logic nopre, int mode, logic [63:0] cw,
                       logic cb8, logic poke);
    int npre = nopre ? 0 : 2;
    int n = b8 ? 8 : 4;
    int len = npre + n + ((mode == 0) ? 2 : (mode == 2) ? 1 : 0);
    if (!preset) begin
      @(negedge clk);
      launch = 1'b1; core_word = w0; burst8 = b8; hi_off = ho;
    end
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (k < npre)
        chk(preset ? "R2 R11 preamble" : (poke ? "R2 R9 preamble" : "R2 preamble"),
            ev(1, 16'h0, 1'b0, ho));
      else if (k < npre + n) begin
        int i = k - npre;
        logic [63:0] w = (i < 4) ? w0 : w1;
        chk(nopre ? "R10 R3 R4 chained data" :
            (i >= 4 ? "R5 R4 R7 second word" :
             (ho ? "R8 R3 R4 data" : (poke ? "R9 R3 data" : "R3 R4 R7 data"))),
            ev(2, w[16*(i%4) +: 16], (i % 2) == 0, ho));
      end else if (k == npre + n)
        chk("R6 postamble", ev(1, 16'h0, 1'b0, ho));
      else
        chk("R6 release", ev(0, 16'h0, 1'b0, ho));
      if (k == 0) begin launch = 1'b0; core_word = w1; end
      if (poke && !nopre && (k == 0 || k == npre + 1)) begin
        launch = 1'b1; core_word = '1;
      end
      if (poke && !nopre && (k == 1 || k == npre + 2)) begin
        launch = 1'b0; core_word = w1;
      end
      if ((mode == 1 && k == npre + n - 1) || (mode == 2 && k == npre + n)) begin
        launch = 1'b1; core_word = cw; burst8 = cb8;
      end
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    nfail++;
    $display("FAIL watchdog R1 got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", ev(0, 16'h0, 1'b0, 1'b0));
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", ev(0, 16'h0, 1'b0, 1'b0));

    for (int v = 0; v < NV; v++)
      burst(W0[v], W1[v], B8[v], HO[v], 1'b0, 1'b0, 0, 64'h0, 1'b0, 1'b0);

    // R9: launches during preamble and mid-data are ignored
    burst(64'h0807_0605_0403_0201, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 64'h0, 1'b0, 1'b1);

    // R10: gapless chaining, four then eight then four
    burst(64'h1111_2222_3333_4444, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1,
          64'hC0C1_C2C3_C4C5_C6C7, 1'b1, 1'b0);
    burst(64'hC0C1_C2C3_C4C5_C6C7, 64'hD0D1_D2D3_D4D5_D6D7, 1'b1, 1'b0, 1'b1, 1'b1, 1,
          64'hE0E1_E2E3_E4E5_E6E7, 1'b0, 1'b0);
    burst(64'hE0E1_E2E3_E4E5_E6E7, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1, 0, 64'h0, 1'b0, 1'b0);

    // R11: launch in postamble gets a full preamble
    burst(64'h0A0B_0C0D_0E0F_1011, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 2,
          64'h7172_7374_7576_7778, 1'b0, 1'b0);
    burst(64'h7172_7374_7576_7778, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 64'h0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule